// File: doc/BRIEF.md
# Greedy Local-Search Satisfiability Controller

This block is the control unit of a hardware solver for Boolean satisfiability. It searches greedily and locally. The problem instance lives in a small writable occurrence memory. The host loads it through a write port while the solver sits idle. There is one word per variable, and each word tells, for every clause, whether that variable occurs in it and which value of the variable satisfies that occurrence.

A start pulse begins a run. The controller first takes a pseudo-random starting assignment from a free-running maximal-length LFSR. It then walks the variables once to build the per-clause counts of satisfied literals in a clause counter bank. After that it repeats rounds:

- It checks whether every clause is satisfied.
- It scores the flip of each variable in turn by previewing the satisfied-clause count the flip would give.
- It commits the flip of the best-scoring variable.

Equal scores are settled by a random bit. Rounds whose best gain is zero or negative are counted. When that count reaches a fixed budget, the run stops with a failure flag. A successful run raises a done flag and presents the satisfying assignment. Both flags stay set until the next start.

Top module: `gsat_top`

## Requirements
- R1: After reset, `done` and `fail` are both 0.
- R2: The word at address v describes variable v. For clause c, bit 2c+1 set means v occurs in c, and bit 2c gives the value of v that satisfies that occurrence. A clause whose bits are clear in every word is never satisfied.
- R3: A start pulse sampled on a rising edge clears `done` and `fail` by the following edge. The run then loads a pseudo-random assignment and builds the clause counts before the first round.
- R4: A round begins by checking whether all NUM_CLAUSES clauses are satisfied. If they are, `done` rises and `assignment` shows an assignment that satisfies every clause.
- R5: Each round scores all NUM_VARS variables and then flips exactly one variable, the one with the highest gain. Outside the two cycles after a start, `assignment` changes by at most one bit per clock.
- R6: When two variables have equal gain, a random bit decides whether the later one replaces the earlier choice.
- R7: A round whose best gain is zero or negative increments the attempt counter. The round that brings it to MAX_ATTEMPTS raises `fail`. For an instance that never improves, `fail` rises on the edge 1+NUM_VARS+MAX_ATTEMPTS*(NUM_VARS+1) edges after the edge that samples start.
- R8: `done` and `fail` are never both 1. Each stays set, with `assignment` held, until the next start.
- R9: An instance made of one single-literal clause per variable always ends with `done` and exactly the planted assignment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | One-cycle pulse that begins a run |
| wr_en | input | 1 | Occurrence memory write enable |
| wr_addr | input | $clog2(NUM_VARS) | Variable number to write |
| wr_data | input | 2*NUM_CLAUSES | Occurrence word |
| done | output | 1 | Sticky success flag |
| fail | output | 1 | Sticky attempt-budget-exhausted flag |
| assignment | output | NUM_VARS | Current or satisfying assignment |

## Verification
The bench sweeps every planted assignment of a four-variable unit-clause instance. In that instance all wrong bits tie at gain +1, so a faulty tie-break or a wrong flip index would leave a bit wrong or flip a correct one. An instance of empty clauses never improves, which pins the exact failure latency. An off-by-one in the attempt compare or the round length shifts that edge. A contradictory instance must fail and never claim success. The bench also repeats runs of a multi-literal instance and evaluates each result against the clauses. It then checks that the flags are sticky and that a new start clears them. A design that cleared the flags late or changed the assignment after success would be caught there.

// File: rtl/gsat_pkg.sv
package gsat_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_INIT  = 3'd1,
    ST_CINIT = 3'd2,
    ST_FLIP  = 3'd3,
    ST_MAXM  = 3'd4,
    ST_DONE  = 3'd5,
    ST_FAIL  = 3'd6
  } gsat_state_e;
endpackage

// File: rtl/gsat_lfsr.sv
module gsat_lfsr #(
  parameter int          WIDTH = 16,
  parameter logic [15:0] TAPS  = 16'hB400,
  parameter logic [15:0] SEED  = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [WIDTH-1:0] state
);
  logic [WIDTH-1:0] state_q, state_d;

  always_comb begin
    if (state_q[0]) state_d = (state_q >> 1) ^ TAPS[WIDTH-1:0];
    else            state_d = state_q >> 1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEED[WIDTH-1:0];
    else        state_q <= state_d;
  end

  assign state = state_q;
endmodule

// File: rtl/gsat_occ_mem.sv
module gsat_occ_mem #(
  parameter int NUM_VARS = 8,
  parameter int WORD_W   = 16,
  localparam int AW      = (NUM_VARS > 1) ? $clog2(NUM_VARS) : 1
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [WORD_W-1:0] rd_data
);
  logic [WORD_W-1:0] mem_q [NUM_VARS];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_addr] <= wr_data;
  end

  assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/gsat_clause_bank.sv
module gsat_clause_bank #(
  parameter int NUM_VARS    = 8,
  parameter int NUM_CLAUSES = 8,
  localparam int WORD_W     = 2 * NUM_CLAUSES,
  localparam int CW         = $clog2(NUM_VARS + 1),
  localparam int SW         = $clog2(NUM_CLAUSES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              add,
  input  logic              commit,
  input  logic [WORD_W-1:0] word,
  input  logic              val,
  output logic [SW-1:0]     cur_sat,
  output logic [SW-1:0]     prev_sat
);
  logic [NUM_CLAUSES-1:0] sat_now, sat_flip;

  for (genvar c = 0; c < NUM_CLAUSES; c++) begin : g_clause
    logic [CW-1:0] cnt_q, cnt_d, cnt_flip;
    logic          pres, lit_ok;

    assign pres   = word[2*c+1];
    assign lit_ok = pres && (word[2*c] == val);

    always_comb begin
      if (!pres)       cnt_flip = cnt_q;
      else if (lit_ok) cnt_flip = cnt_q - CW'(1);
      else             cnt_flip = cnt_q + CW'(1);
    end

    always_comb begin
      cnt_d = cnt_q;
      if (clr)              cnt_d = '0;
      else if (add && lit_ok) cnt_d = cnt_q + CW'(1);
      else if (commit)      cnt_d = cnt_flip;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
    end

    assign sat_now[c]  = (cnt_q != '0);
    assign sat_flip[c] = (cnt_flip != '0);
  end

  always_comb begin
    cur_sat  = '0;
    prev_sat = '0;
    for (int c = 0; c < NUM_CLAUSES; c++) begin
      cur_sat  = cur_sat  + SW'(sat_now[c]);
      prev_sat = prev_sat + SW'(sat_flip[c]);
    end
  end
endmodule

// File: rtl/gsat_ctrl.sv
module gsat_ctrl
  import gsat_pkg::*;
#(
  parameter int NUM_VARS     = 8,
  parameter int NUM_CLAUSES  = 8,
  parameter int MAX_ATTEMPTS = 16,
  localparam int VW          = (NUM_VARS > 1) ? $clog2(NUM_VARS) : 1,
  localparam int SW          = $clog2(NUM_CLAUSES + 1),
  localparam int GW          = SW + 1,
  localparam int ATW         = $clog2(MAX_ATTEMPTS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [NUM_VARS-1:0] rnd_bits,
  input  logic                tie_bit,
  input  logic [SW-1:0]       cur_sat,
  input  logic [SW-1:0]       prev_sat,
  output logic [VW-1:0]       mem_addr,
  output logic                bank_clr,
  output logic                bank_add,
  output logic                bank_commit,
  output logic                var_val,
  output logic                done,
  output logic                fail,
  output logic [NUM_VARS-1:0] assignment
);
  gsat_state_e          state_q, state_d;
  logic [VW-1:0]        idx_q, idx_d;
  logic [VW-1:0]        best_idx_q, best_idx_d;
  logic signed [GW-1:0] best_gain_q, best_gain_d;
  logic [ATW-1:0]       att_q, att_d;
  logic [NUM_VARS-1:0]  asg_q, asg_d;
  logic signed [GW-1:0] gain;
  logic                 last_idx, all_sat, take;

  assign gain     = $signed({1'b0, prev_sat}) - $signed({1'b0, cur_sat});
  assign last_idx = (idx_q == VW'(NUM_VARS - 1));
  assign all_sat  = (cur_sat == SW'(NUM_CLAUSES));
  assign take     = (idx_q == '0) || (gain > best_gain_q) ||
                    ((gain == best_gain_q) && tie_bit);
  assign mem_addr = (state_q == ST_MAXM) ? best_idx_q : idx_q;
  assign var_val  = asg_q[mem_addr];

  always_comb begin
    state_d     = state_q;
    idx_d       = idx_q;
    best_idx_d  = best_idx_q;
    best_gain_d = best_gain_q;
    att_d       = att_q;
    asg_d       = asg_q;
    bank_clr    = 1'b0;
    bank_add    = 1'b0;
    bank_commit = 1'b0;
    case (state_q)
      ST_IDLE, ST_DONE, ST_FAIL: begin
        if (start) state_d = ST_INIT;
      end
      ST_INIT: begin
        bank_clr = 1'b1;
        asg_d    = rnd_bits;
        att_d    = '0;
        idx_d    = '0;
        state_d  = ST_CINIT;
      end
      ST_CINIT: begin
        bank_add = 1'b1;
        if (last_idx) begin
          idx_d   = '0;
          state_d = ST_FLIP;
        end else begin
          idx_d = idx_q + VW'(1);
        end
      end
      ST_FLIP: begin
        if ((idx_q == '0) && all_sat) begin
          state_d = ST_DONE;
        end else begin
          if (take) begin
            best_gain_d = gain;
            best_idx_d  = idx_q;
          end
          if (last_idx) begin
            idx_d   = '0;
            state_d = ST_MAXM;
          end else begin
            idx_d = idx_q + VW'(1);
          end
        end
      end
      ST_MAXM: begin
        bank_commit           = 1'b1;
        asg_d[best_idx_q]     = ~asg_q[best_idx_q];
        idx_d                 = '0;
        state_d               = ST_FLIP;
        if (best_gain_q <= 0) begin
          if (att_q == ATW'(MAX_ATTEMPTS - 1)) state_d = ST_FAIL;
          else                                 att_d   = att_q + ATW'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      idx_q       <= '0;
      best_idx_q  <= '0;
      best_gain_q <= '0;
      att_q       <= '0;
      asg_q       <= '0;
    end else begin
      state_q     <= state_d;
      idx_q       <= idx_d;
      best_idx_q  <= best_idx_d;
      best_gain_q <= best_gain_d;
      att_q       <= att_d;
      asg_q       <= asg_d;
    end
  end

  assign done       = (state_q == ST_DONE);
  assign fail       = (state_q == ST_FAIL);
  assign assignment = asg_q;
endmodule

// File: rtl/gsat_top.sv
module gsat_top #(
  parameter int          NUM_VARS     = 8,
  parameter int          NUM_CLAUSES  = 8,
  parameter int          MAX_ATTEMPTS = 16,
  parameter int          LFSR_W       = 16,
  parameter logic [15:0] LFSR_SEED    = 16'hACE1,
  localparam int         VW           = (NUM_VARS > 1) ? $clog2(NUM_VARS) : 1,
  localparam int         WORD_W       = 2 * NUM_CLAUSES,
  localparam int         SW           = $clog2(NUM_CLAUSES + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                wr_en,
  input  logic [VW-1:0]       wr_addr,
  input  logic [WORD_W-1:0]   wr_data,
  output logic                done,
  output logic                fail,
  output logic [NUM_VARS-1:0] assignment
);
  logic [1:0]          rst_sync_q;
  logic                rst_core_n;
  logic [LFSR_W-1:0]   lfsr_state;
  logic [NUM_VARS-1:0] rnd_bits;
  logic [VW-1:0]       mem_addr;
  logic [WORD_W-1:0]   mem_word;
  logic                bank_clr, bank_add, bank_commit, var_val;
  logic [SW-1:0]       cur_sat, prev_sat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  gsat_lfsr #(.WIDTH(LFSR_W), .TAPS(16'hB400), .SEED(LFSR_SEED)) u_lfsr (
    .clk(clk), .rst_n(rst_core_n), .state(lfsr_state)
  );

  for (genvar i = 0; i < NUM_VARS; i++) begin : g_rnd
    assign rnd_bits[i] = lfsr_state[i % LFSR_W];
  end

  gsat_occ_mem #(.NUM_VARS(NUM_VARS), .WORD_W(WORD_W)) u_mem (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(mem_addr), .rd_data(mem_word)
  );

  gsat_clause_bank #(.NUM_VARS(NUM_VARS), .NUM_CLAUSES(NUM_CLAUSES)) u_bank (
    .clk(clk), .rst_n(rst_core_n), .clr(bank_clr), .add(bank_add),
    .commit(bank_commit), .word(mem_word), .val(var_val),
    .cur_sat(cur_sat), .prev_sat(prev_sat)
  );

  gsat_ctrl #(.NUM_VARS(NUM_VARS), .NUM_CLAUSES(NUM_CLAUSES),
              .MAX_ATTEMPTS(MAX_ATTEMPTS)) u_ctrl (
    .clk(clk), .rst_n(rst_core_n), .start(start),
    .rnd_bits(rnd_bits), .tie_bit(lfsr_state[LFSR_W-1]),
    .cur_sat(cur_sat), .prev_sat(prev_sat), .mem_addr(mem_addr),
    .bank_clr(bank_clr), .bank_add(bank_add), .bank_commit(bank_commit),
    .var_val(var_val), .done(done), .fail(fail), .assignment(assignment)
  );
endmodule

// File: rtl/gsat_checker.sv
module gsat_checker #(
  parameter int NUM_VARS = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start,
  input logic                done,
  input logic                fail,
  input logic [NUM_VARS-1:0] assignment
);
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail)); // R8

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done); // R8

  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !start) |=> fail); // R8

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ((done || fail) && !start) |=> $stable(assignment)); // R8

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (done || fail)) |=> (!done && !fail)); // R3

  AST_SINGLE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(start, 1) && !$past(start, 2)) |->
      ($countones(assignment ^ $past(assignment)) <= 1)); // R5
endmodule

bind gsat_top gsat_checker #(.NUM_VARS(NUM_VARS)) u_checker (
  .clk(clk), .rst_n(rst_n), .start(start), .done(done), .fail(fail),
  .assignment(assignment)
);

// File: tb/gsat_top_test.sv
module gsat_top_test;
  localparam int NV  = 4;
  localparam int NC  = 4;
  localparam int MA  = 8;
  localparam int WW  = 2 * NC;
  localparam int FAIL_EDGES = 2 + NV + MA * (NV + 1);

  logic          clk, rst_n, start, wr_en;
  logic [1:0]    wr_addr;
  logic [WW-1:0] wr_data;
  logic          done, fail;
  logic [NV-1:0] assignment;
  logic [WW-1:0] inst [NV];

  int n_checks = 0;
  int n_fail   = 0;
  int edges;
  logic [NV-1:0] held;

  gsat_top #(.NUM_VARS(NV), .NUM_CLAUSES(NC), .MAX_ATTEMPTS(MA)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .done(done), .fail(fail),
    .assignment(assignment)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load();
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 2'(v); wr_data = inst[v];
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Counts edges from the one that samples start until done or fail shows.
  task automatic run(output int cnt);
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    cnt = 1;
    @(negedge clk);
    start = 1'b0;
    while (!done && !fail && cnt < 3000) begin
      @(posedge clk);
      cnt++;
      @(negedge clk);
    end
  endtask

  function automatic logic satisfies(input logic [NV-1:0] a);
    logic ok = 1'b1;
    for (int c = 0; c < NC; c++) begin
      logic hit = 1'b0;
      for (int v = 0; v < NV; v++)
        if (inst[v][2*c+1] && (inst[v][2*c] == a[v])) hit = 1'b1;
      ok &= hit;
    end
    return ok;
  endfunction

  initial begin
    #2000000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 done after reset", done, 0);
    check("R1 fail after reset", fail, 0);

    // R9, R6, R4, R2: unit clauses, clause v holds variable v; wrong bits tie at +1.
    for (int p = 0; p < (1 << NV); p++) begin
      for (int v = 0; v < NV; v++)
        inst[v] = WW'((2'b10 | 2'(p[v])) << (2 * v));
      load();
      run(edges);
      check("R9 done for planted instance", {fail, done}, 2'b01);
      check("R9 R6 planted assignment", assignment, 32'(p));
    end

    // R8: result sticky and held, R3: start clears it.
    held = assignment;
    repeat (6) @(negedge clk);
    check("R8 done sticky", {fail, done}, 2'b01);
    check("R8 assignment held", assignment, held);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R3 start clears done", {fail, done}, 2'b00);
    while (!done && !fail) @(negedge clk);

    // R2, R7: all clauses empty; never improves; exact failure edge.
    for (int v = 0; v < NV; v++) inst[v] = '0;
    load();
    run(edges);
    check("R7 fail raised", {fail, done}, 2'b10);
    check("R7 fail latency in edges", edges, FAIL_EDGES);
    repeat (4) @(negedge clk);
    check("R8 fail sticky", {fail, done}, 2'b10);

    // R7: contradictory unit clauses on variable 0.
    inst[0] = 8'b0000_1011;
    for (int v = 1; v < NV; v++) inst[v] = '0;
    load();
    run(edges);
    check("R7 unsatisfiable ends in fail", {fail, done}, 2'b10);

    // R4, R5: multi-literal instance, several random starts.
    inst[0] = 8'b1100_0011;
    inst[1] = 8'b0011_0011;
    inst[2] = 8'b1100_1000;
    inst[3] = 8'b0010_1100;
    load();
    for (int r = 0; r < 6; r++) begin
      run(edges);
      check("R4 R5 mixed instance done", {fail, done}, 2'b01);
      check("R4 assignment satisfies clauses", satisfies(assignment), 1);
      repeat (r + 1) @(negedge clk);
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule